// File: doc/BRIEF.md
# Aliased Sub-Register File

This block is a small file of general-purpose registers. Each physical 64-bit register can be reached under several nested names. Four base registers (indices 0 to 3) can each be addressed as follows:

- its low byte;
- its second byte;
- the 16-bit word formed by those two bytes;
- a 32-bit extended view whose bottom half is that word;
- the full 64-bit register, whose lower half is the extended view.

A wide-mode input unlocks eight more 64-bit registers at indices 8 to 15. Indices 4 to 7 never exist.

The file has one write port and two read ports. Every port carries an enable, a 4-bit register index and a 3-bit part selector. A narrow write only replaces the bits its part covers, and the rest of the register keeps its value. This lets a datapath build up a register one byte or one word at a time. A narrow read returns the selected bits right-aligned, with zeros above them. Any access that names a register that does not exist, or an unknown part code, raises that port's error flag. Such an access changes nothing.

Top module: `subreg_file`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) sets every register to zero, and any legal read after it returns zero.
- R2: Part code 0 (low byte) writes replace bits 7:0 of the register and leave bits 63:8 unchanged.
- R3: Part code 1 (high byte) writes take bits 7:0 of the write data into bits 15:8 of the register and leave all other bits unchanged.
- R4: Part code 2 (word) writes replace bits 15:0 only. The word read afterwards equals the high-byte read placed above the low-byte read.
- R5: Part code 3 (extended) writes replace bits 31:0 only. Part code 4 (full) writes replace all 64 bits.
- R6: A read returns the selected part right-aligned and zero-extended to 64 bits. Part 0 returns bits 7:0, part 1 returns bits 15:8, part 2 returns bits 15:0, part 3 returns bits 31:0 and part 4 returns bits 63:0.
- R7: While `wide_en` is low, any enabled access to indices 8 to 15 raises the port's error flag. A write of this kind leaves the register unchanged, and a read of this kind returns zero. While `wide_en` is high, these indices work normally.
- R8: Indices 4 to 7 and part codes 5 to 7 are always errors, with the same effects as in R7.
- R9: A read issued in the same cycle as a write to the same register returns the old value. The new value is visible from the next cycle.
- R10: The two read ports work independently and can read different registers and parts in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| wide_en | input | 1 | Unlocks registers 8 to 15 |
| wr_en | input | 1 | Write request |
| wr_idx | input | 4 | Write register index |
| wr_part | input | 3 | Write part selector |
| wr_data | input | 64 | Write data, right-aligned for narrow parts |
| wr_err | output | 1 | Write request is illegal and was dropped |
| rd0_en | input | 1 | Read port 0 enable |
| rd0_idx | input | 4 | Read port 0 register index |
| rd0_part | input | 3 | Read port 0 part selector |
| rd0_data | output | 64 | Read port 0 data, zero-extended |
| rd0_err | output | 1 | Read port 0 request is illegal |
| rd1_en | input | 1 | Read port 1 enable |
| rd1_idx | input | 4 | Read port 1 register index |
| rd1_part | input | 3 | Read port 1 part selector |
| rd1_data | output | 64 | Read port 1 data, zero-extended |
| rd1_err | output | 1 | Read port 1 request is illegal |

## Verification
The bound checker watches the following on every cycle:

- a flagged write never commits;
- a flagged read returns zero;
- a low-byte read keeps its upper bits clear;
- a full-width read right after a full-width write returns that data;
- the first read after reset returns zero.

Only the bench's scenarios can show that partial writes merge correctly into the neighbouring bits over a chain of writes of mixed widths. The same holds for extended registers keeping their contents while locked, and for the old-value result of a read in the same cycle as a write.

// File: rtl/subreg_pkg.sv
package subreg_pkg;
  localparam int DATA_W = 64;

  localparam logic [2:0] PART_LO8 = 3'd0;
  localparam logic [2:0] PART_HI8 = 3'd1;
  localparam logic [2:0] PART_W16 = 3'd2;
  localparam logic [2:0] PART_X32 = 3'd3;
  localparam logic [2:0] PART_Q64 = 3'd4;

  function automatic logic part_known(input logic [2:0] p);
    return p <= PART_Q64;
  endfunction

  // Selected view, right-aligned and zero-extended
  function automatic logic [DATA_W-1:0] view_get(input logic [DATA_W-1:0] r,
                                                 input logic [2:0] p);
    case (p)
      PART_LO8: return {56'b0, r[7:0]};
      PART_HI8: return {56'b0, r[15:8]};
      PART_W16: return {48'b0, r[15:0]};
      PART_X32: return {32'b0, r[31:0]};
      PART_Q64: return r;
      default:  return '0;
    endcase
  endfunction

  // Fold a right-aligned narrow value into the full register
  function automatic logic [DATA_W-1:0] view_merge(input logic [DATA_W-1:0] old,
                                                   input logic [DATA_W-1:0] d,
                                                   input logic [2:0] p);
    case (p)
      PART_LO8: return {old[63:8], d[7:0]};
      PART_HI8: return {old[63:16], d[7:0], old[7:0]};
      PART_W16: return {old[63:16], d[15:0]};
      PART_X32: return {old[63:32], d[31:0]};
      PART_Q64: return d;
      default:  return old;
    endcase
  endfunction
endpackage

// File: rtl/subreg_decode.sv
module subreg_decode #(
  parameter int NUM_BASE  = 4,
  parameter int WIDE_BASE = 8,
  parameter int NUM_WIDE  = 8,
  parameter int IDX_W     = 4,
  parameter int SLOT_W    = 4
) (
  input  logic [IDX_W-1:0]  idx,
  input  logic [2:0]        part,
  input  logic              wide_en,
  output logic              legal,
  output logic [SLOT_W-1:0] slot
);
  import subreg_pkg::*;
  localparam int WIDE_END = WIDE_BASE + NUM_WIDE;

  logic is_base, is_wide;
  int   ii;

  always_comb begin
    ii      = int'(idx);
    is_base = ii < NUM_BASE;
    is_wide = wide_en && (ii >= WIDE_BASE) && (ii < WIDE_END);
    legal   = (is_base || is_wide) && part_known(part);
    if (is_base) slot = SLOT_W'(ii);
    else         slot = SLOT_W'(ii - WIDE_BASE + NUM_BASE);
  end
endmodule

// File: rtl/subreg_store.sv
module subreg_store #(
  parameter int NUM_SLOTS = 12,
  parameter int SLOT_W    = 4
) (
  input  logic                                   clk,
  input  logic                                   rst,
  input  logic                                   commit,
  input  logic [SLOT_W-1:0]                      slot,
  input  logic [2:0]                             part,
  input  logic [subreg_pkg::DATA_W-1:0]          data,
  output logic [NUM_SLOTS-1:0][subreg_pkg::DATA_W-1:0] regs_q
);
  import subreg_pkg::*;

  always_ff @(posedge clk) begin
    if (rst) begin
      regs_q <= '0;
    end else if (commit) begin
      regs_q[slot] <= view_merge(regs_q[slot], data, part);
    end
  end
endmodule

// File: rtl/subreg_rdport.sv
module subreg_rdport #(
  parameter int NUM_BASE  = 4,
  parameter int WIDE_BASE = 8,
  parameter int NUM_WIDE  = 8,
  parameter int IDX_W     = 4,
  parameter int SLOT_W    = 4,
  parameter int NUM_SLOTS = 12
) (
  input  logic                                   en,
  input  logic [IDX_W-1:0]                       idx,
  input  logic [2:0]                             part,
  input  logic                                   wide_en,
  input  logic [NUM_SLOTS-1:0][subreg_pkg::DATA_W-1:0] regs_q,
  output logic [subreg_pkg::DATA_W-1:0]          data,
  output logic                                   err
);
  import subreg_pkg::*;
  logic              legal;
  logic [SLOT_W-1:0] slot;

  subreg_decode #(.NUM_BASE(NUM_BASE), .WIDE_BASE(WIDE_BASE), .NUM_WIDE(NUM_WIDE),
                  .IDX_W(IDX_W), .SLOT_W(SLOT_W)) dec_i (
    .idx(idx), .part(part), .wide_en(wide_en), .legal(legal), .slot(slot));

  always_comb begin
    err  = en && !legal;
    data = (en && legal) ? view_get(regs_q[slot], part) : '0;
  end
endmodule

// File: rtl/subreg_file.sv
module subreg_file #(
  parameter int NUM_BASE  = 4,
  parameter int WIDE_BASE = 8,
  parameter int NUM_WIDE  = 8,
  parameter int IDX_W     = 4
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        wide_en,
  input  logic        wr_en,
  input  logic [3:0]  wr_idx,
  input  logic [2:0]  wr_part,
  input  logic [63:0] wr_data,
  output logic        wr_err,
  input  logic        rd0_en,
  input  logic [3:0]  rd0_idx,
  input  logic [2:0]  rd0_part,
  output logic [63:0] rd0_data,
  output logic        rd0_err,
  input  logic        rd1_en,
  input  logic [3:0]  rd1_idx,
  input  logic [2:0]  rd1_part,
  output logic [63:0] rd1_data,
  output logic        rd1_err
);
  import subreg_pkg::*;
  localparam int NUM_SLOTS = NUM_BASE + NUM_WIDE;
  localparam int SLOT_W    = $clog2(NUM_SLOTS);
  localparam int NUM_RD    = 2;

  logic [NUM_SLOTS-1:0][DATA_W-1:0] regs_q;
  logic              wr_legal;
  logic [SLOT_W-1:0] wr_slot;
  logic              wr_commit;   // named event for the checker

  subreg_decode #(.NUM_BASE(NUM_BASE), .WIDE_BASE(WIDE_BASE), .NUM_WIDE(NUM_WIDE),
                  .IDX_W(IDX_W), .SLOT_W(SLOT_W)) wdec_i (
    .idx(wr_idx), .part(wr_part), .wide_en(wide_en), .legal(wr_legal), .slot(wr_slot));

  assign wr_err    = wr_en && !wr_legal;
  assign wr_commit = wr_en && wr_legal && !rst;

  subreg_store #(.NUM_SLOTS(NUM_SLOTS), .SLOT_W(SLOT_W)) store_i (
    .clk(clk), .rst(rst), .commit(wr_commit), .slot(wr_slot),
    .part(wr_part), .data(wr_data), .regs_q(regs_q));

  logic [NUM_RD-1:0]             r_en, r_err;
  logic [NUM_RD-1:0][IDX_W-1:0]  r_idx;
  logic [NUM_RD-1:0][2:0]        r_part;
  logic [NUM_RD-1:0][DATA_W-1:0] r_data;

  assign r_en   = {rd1_en, rd0_en};
  assign r_idx  = {rd1_idx, rd0_idx};
  assign r_part = {rd1_part, rd0_part};

  for (genvar g = 0; g < NUM_RD; g++) begin : g_rd
    subreg_rdport #(.NUM_BASE(NUM_BASE), .WIDE_BASE(WIDE_BASE), .NUM_WIDE(NUM_WIDE),
                    .IDX_W(IDX_W), .SLOT_W(SLOT_W), .NUM_SLOTS(NUM_SLOTS)) rp_i (
      .en(r_en[g]), .idx(r_idx[g]), .part(r_part[g]), .wide_en(wide_en),
      .regs_q(regs_q), .data(r_data[g]), .err(r_err[g]));
  end

  assign rd0_data = r_data[0];
  assign rd0_err  = r_err[0];
  assign rd1_data = r_data[1];
  assign rd1_err  = r_err[1];
endmodule

// File: rtl/subreg_file_chk.sv
module subreg_file_chk (
  input logic        clk,
  input logic        rst,
  input logic        wr_en,
  input logic [3:0]  wr_idx,
  input logic [2:0]  wr_part,
  input logic [63:0] wr_data,
  input logic        wr_err,
  input logic        wr_commit,
  input logic        rd0_en,
  input logic [3:0]  rd0_idx,
  input logic [2:0]  rd0_part,
  input logic [63:0] rd0_data,
  input logic        rd0_err
);
  // R7
  err_blocks_write_chk: assert property (@(posedge clk) disable iff (rst)
    wr_err |-> !wr_commit);

  // R8
  err_read_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (rd0_en && rd0_err) |-> (rd0_data == 64'd0));

  // R6
  lo8_zero_ext_chk: assert property (@(posedge clk) disable iff (rst)
    (rd0_en && !rd0_err && rd0_part == 3'd0) |-> (rd0_data[63:8] == 56'd0));

  // R9
  full_write_visible_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(wr_commit) && $past(wr_part) == 3'd4 && rd0_en && !rd0_err &&
     rd0_part == 3'd4 && rd0_idx == $past(wr_idx)) |-> (rd0_data == $past(wr_data)));

  // R1
  reset_clears_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(rst) && rd0_en && !rd0_err) |-> (rd0_data == 64'd0));
endmodule

bind subreg_file subreg_file_chk chk_i (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx), .wr_part(wr_part),
  .wr_data(wr_data), .wr_err(wr_err), .wr_commit(wr_commit),
  .rd0_en(rd0_en), .rd0_idx(rd0_idx), .rd0_part(rd0_part),
  .rd0_data(rd0_data), .rd0_err(rd0_err));

// File: tb/subreg_file_tb_top.sv
`timescale 1ns/1ps
module subreg_file_tb_top;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst, wide_en, wr_en, rd0_en, rd1_en;
  logic [3:0]  wr_idx, rd0_idx, rd1_idx;
  logic [2:0]  wr_part, rd0_part, rd1_part;
  logic [63:0] wr_data, rd0_data, rd1_data;
  logic        wr_err, rd0_err, rd1_err;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  subreg_file dut_i (.*);

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] i, input logic [2:0] p, input logic [63:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = i; wr_part = p; wr_data = d;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] i, input logic [2:0] p);
    rd0_en = 1'b1; rd0_idx = i; rd0_part = p; #1;
  endtask

  typedef struct packed {
    logic        we;
    logic [3:0]  wi;
    logic [2:0]  wp;
    logic [63:0] wd;
    logic [3:0]  ri;
    logic [2:0]  rp;
    logic [63:0] exp;
  } vec_t;

  localparam vec_t TAB [8] = '{
    '{1'b1, 4'd1, 3'd4, 64'h1122334455667788, 4'd1, 3'd4, 64'h1122334455667788}, // R5
    '{1'b1, 4'd1, 3'd0, 64'hFFFFFFFFFFFFFFAA, 4'd1, 3'd4, 64'h11223344556677AA}, // R2
    '{1'b1, 4'd1, 3'd1, 64'hFFFFFFFFFFFFFFBB, 4'd1, 3'd1, 64'h00000000000000BB}, // R3
    '{1'b1, 4'd1, 3'd2, 64'hDEADBEEF0000CDEF, 4'd1, 3'd0, 64'h00000000000000EF}, // R4
    '{1'b1, 4'd1, 3'd3, 64'hAAAAAAAA0BADF00D, 4'd1, 3'd4, 64'h112233440BADF00D}, // R5
    '{1'b1, 4'd9, 3'd4, 64'h0123456789ABCDEF, 4'd9, 3'd2, 64'h000000000000CDEF}, // R6
    '{1'b1, 4'd2, 3'd1, 64'h000000000000005A, 4'd2, 3'd4, 64'h0000000000005A00}, // R3
    '{1'b0, 4'd0, 3'd0, 64'h0,                4'd1, 3'd3, 64'h000000000BADF00D}  // R6
  };

  initial begin
    #(4 * 100000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; wide_en = 1'b1; wr_en = 1'b0; rd0_en = 1'b0; rd1_en = 1'b0;
    wr_idx = '0; wr_part = '0; wr_data = '0;
    rd0_idx = '0; rd0_part = '0; rd1_idx = '0; rd1_part = '0;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    // R1 reset state
    rd(4'd0, 3'd4); check("R1 reg0", rd0_data, 64'd0);
    rd(4'd12, 3'd4); check("R1 reg12", rd0_data, 64'd0);

    for (int k = 0; k < 8; k++) begin
      if (TAB[k].we) wr(TAB[k].wi, TAB[k].wp, TAB[k].wd);
      rd(TAB[k].ri, TAB[k].rp);
      check($sformatf("R2-6 vector %0d", k), rd0_data, TAB[k].exp);
    end

    // R4 word = high byte over low byte
    rd(4'd1, 3'd2); check("R4 word", rd0_data, 64'hF00D);
    rd(4'd1, 3'd1); check("R4 hi", rd0_data, 64'hF0);

    // R7 locked extended registers
    @(negedge clk); wide_en = 1'b0;
    wr(4'd9, 3'd4, 64'hFFFFFFFFFFFFFFFF);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = 4'd9; wr_part = 3'd4; #1;
    check("R7 wr_err", {63'd0, wr_err}, 64'd1);
    wr_en = 1'b0;
    rd(4'd9, 3'd4);
    check("R7 rd_err", {63'd0, rd0_err}, 64'd1);
    check("R7 rd zero", rd0_data, 64'd0);
    @(negedge clk); wide_en = 1'b1; #1;
    rd(4'd9, 3'd4); check("R7 unchanged", rd0_data, 64'h0123456789ABCDEF);

    // R8 holes and bad part codes
    wr(4'd5, 3'd4, 64'h77);
    wr(4'd0, 3'd6, 64'h77);
    rd(4'd0, 3'd4); check("R8 bad part no write", rd0_data, 64'd0);
    rd(4'd5, 3'd0);
    check("R8 hole err", {63'd0, rd0_err}, 64'd1);
    rd(4'd0, 3'd7);
    check("R8 part err", {63'd0, rd0_err}, 64'd1);

    // R9 same-cycle read sees old value
    @(negedge clk);
    wr_en = 1'b1; wr_idx = 4'd3; wr_part = 3'd4; wr_data = 64'h5555AAAA5555AAAA;
    rd(4'd3, 3'd4); check("R9 old", rd0_data, 64'd0);
    @(posedge clk); #1; wr_en = 1'b0;
    check("R9 new", rd0_data, 64'h5555AAAA5555AAAA);

    // R10 both read ports
    @(negedge clk);
    rd1_en = 1'b1; rd1_idx = 4'd2; rd1_part = 3'd1;
    rd(4'd1, 3'd3);
    check("R10 port0", rd0_data, 64'h0BADF00D);
    check("R10 port1", rd1_data, 64'h5A);
    rd1_en = 1'b0; #1;
    check("R10 port1 disabled", rd1_data, 64'd0);

    // R1 reset after writes
    @(negedge clk); rst = 1'b1;
    @(posedge clk); #1 rst = 1'b0;
    rd(4'd1, 3'd4); check("R1 after reset", rd0_data, 64'd0);
    rd(4'd9, 3'd4); check("R1 wide after reset", rd0_data, 64'd0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule